// File: doc/BRIEF.md
# Half-Word Host Port Bus Master

This block sits in an FPGA and acts as the master of an asynchronous 16-bit host port on a slave processor. It lets a local 32-bit requester reach the slave's memory. The requester issues one of three commands. It can load the slave's control register, load its address pointer, or move one 32-bit data word. A data word is either written or read, and the pointer can either advance after the word or stay where it is.

Every command is carried as two 16-bit phases, with the low half first and then the high half. For each phase the block asserts chip select, then drives the direction, register-select and half-word-select lines. It then waits out a setup interval and waits until a synchronized copy of the slave's ready line shows the accepting state. Only then does it pulse the data strobe for a fixed number of cycles and hold the controls for a fixed number of cycles afterwards. Chip select may be kept asserted after a command so that a burst of commands runs under one select. The address strobe stays high, and the second strobe input of the slave is tied to a constant low level.

Top module: `hpb_master`

## Requirements
- R1: While and after reset, with no command issued: `hp_cs_n`=1, `hp_ds_n`=1, `req_busy`=0, `rsp_valid`=0, and `hp_data` is not driven (high impedance).
- R2: Every command produces exactly two strobes. The first has `hp_upper`=0 and carries bits 15:0 of the word. The second has `hp_upper`=1 and carries bits 31:16.
- R3: The data strobe goes low only while chip select is low and the slave's ready line (`hp_rdy_busy`, 1 = busy) is in its accepting state. A busy slave stalls the strobe until the line clears.
- R4: `hp_rw`, `hp_sel` and `hp_upper` are stable from at least one cycle before the strobe falls until the cycle after it rises. The strobe stays low for exactly STRB_CYC clock cycles.
- R5: The register-select code `hp_sel` is 00 for the control load, 01 for the address load, 10 for a data word with pointer advance, and 11 for a data word at a fixed address. `req_cmd` 0 = control, 1 = address, 2 or 3 = data, and `req_fixed`=1 picks code 11.
- R6: A data read returns {high half, low half} on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R7: `req_busy` is high from the cycle after a command is accepted until the command finishes. A `req_valid` seen while busy is ignored and starts no strobe.
- R8: The block drives `hp_data` only during write commands (`hp_rw`=0). During a read it leaves the bus undriven whenever the strobe is high.
- R9: With `req_keep_sel`=1, chip select stays low after the command ends. With 0, it returns high when the command ends.
- R10: `hp_as_n` is constantly 1 and `hp_ds_tie` is constantly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request, taken when idle |
| req_cmd | input | 2 | 0 control load, 1 address load, 2/3 data word |
| req_write | input | 1 | Data command direction: 1 write, 0 read |
| req_fixed | input | 1 | Data command without pointer advance |
| req_keep_sel | input | 1 | Keep chip select asserted after this command |
| req_wdata | input | 32 | Word to write |
| req_busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle pulse: read word ready |
| rsp_rdata | output | 32 | Assembled read word |
| hp_cs_n | output | 1 | Chip select, active low |
| hp_rw | output | 1 | 1 read, 0 write |
| hp_sel | output | 2 | Register select code |
| hp_upper | output | 1 | Half-word select: 0 low half, 1 high half |
| hp_ds_n | output | 1 | Data strobe, active low |
| hp_ds_tie | output | 1 | Fixed level for the unused strobe input |
| hp_as_n | output | 1 | Address strobe, held inactive |
| hp_rdy_busy | input | 1 | Slave ready line, 1 = busy |
| hp_data | inout | 16 | Host port data bus |

## Verification
A bus-level slave model in the bench stores the control and address registers and a small memory, and it goes busy for a while after each full word. One pattern writes words whose two halves both count up, so that a dropped or swapped half shows up as a wrong concatenation. These words are read back with pointer advance, which checks both phase order and the advance. A second pattern writes two different words at a fixed address and reads once, which separates the fixed code from the advancing one. Further runs force a long busy period before a command, which tells a true stall from a strobe issued on a stale ready. They also keep chip select across a burst and inject a request while busy, which shows that the extra request changes nothing.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

    // Register-select code placed on the host port; the slave decodes it.
    typedef enum logic [1:0] {
        HP_SEL_CTRL = 2'b00,
        HP_SEL_ADDR = 2'b01,
        HP_SEL_DINC = 2'b10,
        HP_SEL_DFIX = 2'b11
    } hp_sel_e;

    // Local command codes on req_cmd.
    localparam logic [1:0] LC_CTRL = 2'd0;
    localparam logic [1:0] LC_ADDR = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_STROBE,
        ST_HOLD
    } seq_state_e;

    function automatic hp_sel_e cmd_to_sel(input logic [1:0] cmd, input logic fixed);
        hp_sel_e s;
        case (cmd)
            LC_CTRL: s = HP_SEL_CTRL;
            LC_ADDR: s = HP_SEL_ADDR;
            default: s = fixed ? HP_SEL_DFIX : HP_SEL_DINC;
        endcase
        return s;
    endfunction

    function automatic logic cmd_is_data(input logic [1:0] cmd);
        return cmd[1];
    endfunction

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/hpb_split.sv
module hpb_split #(
    parameter int WORD_W = 32,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic              upper,
    output logic [HALF_W-1:0] half
);
    always_comb begin
        half = upper ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    end
endmodule

// File: rtl/hpb_seq.sv
module hpb_seq
    import hpb_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SETUP_CYC   = 2,
    parameter int STRB_CYC    = 3,
    parameter int HOLD_CYC    = 1,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic              req_write,
    input  logic              req_fixed,
    input  logic              req_keep_sel,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_busy,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    input  logic              rdy_busy_s,
    input  logic [HALF_W-1:0] rd_half,
    output logic              cs_n,
    output logic              ds_n,
    output logic              rw,
    output logic [1:0]        sel,
    output logic              upper,
    output logic              drive,
    output logic [WORD_W-1:0] wword
);
    // Setup must also cover the synchronizer so ready is fresh after select.
    localparam int SETUP_EFF = (SETUP_CYC > SYNC_STAGES) ? SETUP_CYC : SYNC_STAGES + 1;
    localparam int STRB_EFF  = (STRB_CYC < 1) ? 1 : STRB_CYC;
    localparam int HOLD_EFF  = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
    localparam int MAX_A     = (SETUP_EFF > STRB_EFF) ? SETUP_EFF : STRB_EFF;
    localparam int MAX_CNT   = (MAX_A > HOLD_EFF) ? MAX_A : HOLD_EFF;
    localparam int CW        = $clog2(MAX_CNT + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CW-1:0]     cnt;
        logic              upper;
        logic              cs_n;
        logic              ds_n;
        logic              rw;
        hp_sel_e           sel;
        logic              keep;
        logic              drive;
        logic [WORD_W-1:0] wword;
        logic [HALF_W-1:0] rlo;
        logic [WORD_W-1:0] rword;
        logic              rvalid;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:     ST_IDLE,
        cnt:    '0,
        upper:  1'b0,
        cs_n:   1'b1,
        ds_n:   1'b1,
        rw:     1'b1,
        sel:    HP_SEL_CTRL,
        keep:   1'b0,
        drive:  1'b0,
        wword:  '0,
        rlo:    '0,
        rword:  '0,
        rvalid: 1'b0
    };

    seq_t r_d, r_q;

    always_comb begin
        logic is_rd;
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        is_rd      = cmd_is_data(req_cmd) && !req_write;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_SETUP;
                    r_d.cnt   = CW'(SETUP_EFF - 1);
                    r_d.cs_n  = 1'b0;
                    r_d.upper = 1'b0;
                    r_d.sel   = cmd_to_sel(req_cmd, req_fixed);
                    r_d.rw    = is_rd;
                    r_d.drive = !is_rd;
                    r_d.wword = req_wdata;
                    r_d.keep  = req_keep_sel;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == '0) r_d.st  = ST_WAIT;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_WAIT: begin
                if (!rdy_busy_s) begin
                    r_d.st   = ST_STROBE;
                    r_d.ds_n = 1'b0;
                    r_d.cnt  = CW'(STRB_EFF - 1);
                end
            end
            ST_STROBE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_HOLD;
                    r_d.ds_n = 1'b1;
                    r_d.cnt  = CW'(HOLD_EFF - 1);
                    if (r_q.rw) begin
                        if (r_q.upper) r_d.rword = {rd_half, r_q.rlo};
                        else           r_d.rlo   = rd_half;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == '0) begin
                    if (!r_q.upper) begin
                        r_d.upper = 1'b1;
                        r_d.st    = ST_SETUP;
                        r_d.cnt   = CW'(SETUP_EFF - 1);
                    end else begin
                        r_d.st     = ST_IDLE;
                        r_d.upper  = 1'b0;
                        r_d.drive  = 1'b0;
                        r_d.cs_n   = !r_q.keep;
                        r_d.rvalid = r_q.rw;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SEQ_RST;
        else        r_q <= r_d;
    end

    assign req_busy  = (r_q.st != ST_IDLE);
    assign rsp_valid = r_q.rvalid;
    assign rsp_rdata = r_q.rword;
    assign cs_n      = r_q.cs_n;
    assign ds_n      = r_q.ds_n;
    assign rw        = r_q.rw;
    assign sel       = r_q.sel;
    assign upper     = r_q.upper;
    assign drive     = r_q.drive;
    assign wword     = r_q.wword;

    // R3: a strobe edge follows a synchronized accepting ready
    assert_strobe_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> !$past(rdy_busy_s));
    assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> !cs_n);
    // R4: controls already settled when the strobe is low, and held at its rise
    assert_ctl_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> ($stable(rw) && $stable(sel) && $stable(upper)));
    assert_ctl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> ($stable(rw) && $stable(sel) && $stable(upper)));
    // R6: read result flagged for one cycle only
    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R7: no strobe outside a busy command
    assert_busy_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> req_busy);
endmodule

// File: rtl/hpb_master.sv
module hpb_master
    import hpb_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SETUP_CYC   = 2,
    parameter int STRB_CYC    = 3,
    parameter int HOLD_CYC    = 1,
    parameter int SYNC_STAGES = 2,
    localparam int HALF_W     = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic              req_write,
    input  logic              req_fixed,
    input  logic              req_keep_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              hp_cs_n,
    output logic              hp_rw,
    output logic [1:0]        hp_sel,
    output logic              hp_upper,
    output logic              hp_ds_n,
    output logic              hp_ds_tie,
    output logic              hp_as_n,
    input  logic              hp_rdy_busy,
    inout  wire  [HALF_W-1:0] hp_data
);
    logic              rdy_s;
    logic              drive;
    logic [DATA_W-1:0] wword;
    logic [HALF_W-1:0] wr_half;
    logic [HALF_W-1:0] rd_half;

    hpb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rdy_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (hp_rdy_busy),
        .dout (rdy_s)
    );

    hpb_seq #(
        .WORD_W     (DATA_W),
        .SETUP_CYC  (SETUP_CYC),
        .STRB_CYC   (STRB_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .req_write   (req_write),
        .req_fixed   (req_fixed),
        .req_keep_sel(req_keep_sel),
        .req_wdata   (req_wdata),
        .req_busy    (req_busy),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rdy_busy_s  (rdy_s),
        .rd_half     (rd_half),
        .cs_n        (hp_cs_n),
        .ds_n        (hp_ds_n),
        .rw          (hp_rw),
        .sel         (hp_sel),
        .upper       (hp_upper),
        .drive       (drive),
        .wword       (wword)
    );

    hpb_split #(.WORD_W(DATA_W)) u_split (
        .word (wword),
        .upper(hp_upper),
        .half (wr_half)
    );

    assign hp_data   = drive ? wr_half : {HALF_W{1'bz}};
    assign rd_half   = hp_data;
    assign hp_as_n   = 1'b1;
    assign hp_ds_tie = 1'b0;

    // R8: bus drive only on a selected write
    assert_drive_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (!hp_rw && !hp_cs_n));
    // R2: the high half never strobes before its select is set up
    assert_upper_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hp_upper) |-> hp_ds_n);
endmodule

// File: tb/hpb_master_tb.sv
module hpb_master_tb;
    localparam int STRB = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        req_valid, req_write, req_fixed, req_keep;
    logic [1:0]  req_cmd;
    logic [31:0] req_wdata;
    wire         req_busy, rsp_valid;
    wire  [31:0] rsp_rdata;
    wire         hp_cs_n, hp_rw, hp_upper, hp_ds_n, hp_ds_tie, hp_as_n;
    wire  [1:0]  hp_sel;
    logic        hp_rdy_busy;
    wire  [15:0] hp_data;

    hpb_master u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_write(req_write), .req_fixed(req_fixed), .req_keep_sel(req_keep),
        .req_wdata(req_wdata), .req_busy(req_busy), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .hp_cs_n(hp_cs_n), .hp_rw(hp_rw), .hp_sel(hp_sel),
        .hp_upper(hp_upper), .hp_ds_n(hp_ds_n), .hp_ds_tie(hp_ds_tie),
        .hp_as_n(hp_as_n), .hp_rdy_busy(hp_rdy_busy), .hp_data(hp_data)
    );

    // ---------------- slave model ----------------
    logic        en = 1'b0;
    logic [31:0] s_ctrl = '0, s_addr = '0;
    logic [31:0] s_mem [16];
    logic [15:0] s_lat = '0;
    int          busy_left = 0;
    int          post_busy = 2;
    logic        s_drv;
    logic [15:0] s_rd;

    always_comb begin
        s_drv = en && !hp_cs_n && hp_rw && !hp_ds_n;
        s_rd  = hp_upper ? s_mem[s_addr[3:0]][31:16] : s_mem[s_addr[3:0]][15:0];
        hp_rdy_busy = hp_cs_n ? 1'b1 : (busy_left != 0);
    end
    assign hp_data = s_drv ? s_rd : 16'hzzzz;

    // ---------------- reference and scoreboard ----------------
    logic [31:0] ref_ctrl = '0, ref_addr = '0;
    logic [31:0] ref_mem [16];
    logic [31:0] exp_q [$];
    logic [31:0] cur_word = '0;
    int checks = 0, fails = 0;
    int cyc = 0, strobe_idx = 0, low_len = 0, accept_cyc = 0, first_strobe_cyc = 0;
    logic ds_prev = 1'b1;
    bit done = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: protocol checks, slave commits, scoreboard pops
    always @(negedge clk) begin
        logic [31:0] w;
        cyc++;
        if (busy_left > 0) busy_left--;
        if (en) begin
            if (ds_prev && !hp_ds_n) begin
                check(busy_left == 0 && !hp_cs_n, "R3 strobe while busy/unselected", {31'd0, hp_cs_n}, 32'd0);
                check(hp_upper == strobe_idx[0], "R2 half order", {31'd0, hp_upper}, {31'd0, strobe_idx[0]});
                if (!hp_rw)
                    check(hp_data == (hp_upper ? cur_word[31:16] : cur_word[15:0]), "R8 write half",
                          {16'd0, hp_data}, {16'd0, hp_upper ? cur_word[31:16] : cur_word[15:0]});
                if (strobe_idx == 0) first_strobe_cyc = cyc;
                low_len = 1;
            end else if (!hp_ds_n) begin
                low_len++;
            end
            if (!ds_prev && hp_ds_n) begin
                check(low_len == STRB, "R4 strobe width", low_len, STRB);
                strobe_idx++;
                if (!hp_rw) begin
                    if (!hp_upper) s_lat = hp_data;
                    else begin
                        w = {hp_data, s_lat};
                        case (hp_sel)
                            2'b00: s_ctrl = w;
                            2'b01: s_addr = w;
                            2'b10: begin s_mem[s_addr[3:0]] = w; s_addr = s_addr + 1; end
                            default: s_mem[s_addr[3:0]] = w;
                        endcase
                        busy_left = post_busy;
                    end
                end else if (hp_upper) begin
                    if (hp_sel == 2'b10) s_addr = s_addr + 1;
                    busy_left = post_busy;
                end
            end
            if (!hp_cs_n && hp_rw && hp_ds_n)
                check(hp_data === 16'hzzzz, "R8 bus released on read", {16'd0, hp_data}, 32'd0);
            if (rsp_valid) begin
                if (exp_q.size() == 0) check(0, "R6 unexpected read", rsp_rdata, 32'd0);
                else begin
                    w = exp_q.pop_front();
                    check(rsp_rdata == w, "R6 read word", rsp_rdata, w);
                end
            end
        end
        ds_prev = hp_ds_n;
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [1:0] cmd, input bit wr, input bit fx, input bit keep, input logic [31:0] d);
        @(negedge clk);
        while (req_busy) @(negedge clk);
        cur_word = d; strobe_idx = 0;
        req_cmd = cmd; req_write = wr; req_fixed = fx; req_keep = keep; req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        accept_cyc = cyc;
        check(req_busy == 1'b1, "R7 busy after accept", {31'd0, req_busy}, 32'd1);
    endtask

    task automatic finish_cmd();
        while (req_busy) @(negedge clk);
        check(strobe_idx == 2, "R2 two phases", strobe_idx, 2);
    endtask

    task automatic wr_ctrl(input logic [31:0] v, input bit keep);
        issue(2'd0, 1'b1, 1'b0, keep, v); ref_ctrl = v; finish_cmd();
        check(s_ctrl == ref_ctrl, "R5 control load (sel 00)", s_ctrl, ref_ctrl);
    endtask

    task automatic wr_addr(input logic [31:0] v, input bit keep);
        issue(2'd1, 1'b1, 1'b0, keep, v); ref_addr = v; finish_cmd();
        check(s_addr == ref_addr, "R5 address load (sel 01)", s_addr, ref_addr);
    endtask

    task automatic wr_data(input logic [31:0] v, input bit fx, input bit keep);
        issue(2'd2, 1'b1, fx, keep, v);
        ref_mem[ref_addr[3:0]] = v;
        if (!fx) ref_addr = ref_addr + 1;
        finish_cmd();
        check(s_addr == ref_addr, "R5 pointer after write (sel 10/11)", s_addr, ref_addr);
    endtask

    task automatic rd_data(input bit fx, input bit keep);
        exp_q.push_back(ref_mem[ref_addr[3:0]]);
        issue(2'd3, 1'b0, fx, keep, 32'h0);
        if (!fx) ref_addr = ref_addr + 1;
        finish_cmd();
        @(negedge clk);
        check(exp_q.size() == 0, "R6 read returned", exp_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin s_mem[i] = 32'h0; ref_mem[i] = 32'h0; end
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = 2'd0; req_write = 1'b0;
        req_fixed = 1'b0; req_keep = 1'b0; req_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 / R10 reset state
        check(hp_cs_n == 1 && hp_ds_n == 1, "R1 selects idle in reset", {30'd0, hp_cs_n, hp_ds_n}, 32'd3);
        check(req_busy == 0 && rsp_valid == 0, "R1 local idle in reset", {30'd0, req_busy, rsp_valid}, 32'd0);
        check(hp_data === 16'hzzzz, "R1 bus undriven", {16'd0, hp_data}, 32'd0);
        check(hp_as_n == 1 && hp_ds_tie == 0, "R10 fixed strobes", {30'd0, hp_as_n, hp_ds_tie}, 32'd2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b1;
        check(hp_cs_n == 1 && req_busy == 0, "R1 idle after reset", {30'd0, hp_cs_n, req_busy}, 32'd2);

        // register loads
        wr_ctrl(32'h0000_0005, 1'b0);
        wr_addr(32'd3, 1'b0);
        // advancing writes: both halves count
        for (int i = 0; i < 4; i++) wr_data({16'h1000 + 16'(i), 16'h0100 + 16'(i)}, 1'b0, 1'b0);
        // read back with advance
        wr_addr(32'd3, 1'b0);
        for (int i = 0; i < 4; i++) rd_data(1'b0, 1'b0);
        // fixed address: second write wins, pointer stays
        wr_addr(32'd10, 1'b0);
        wr_data(32'hAAAA_5555, 1'b1, 1'b0);
        wr_data(32'h1234_ABCD, 1'b1, 1'b0);
        rd_data(1'b1, 1'b0);
        rd_data(1'b1, 1'b0);

        // R3 stall on a busy slave
        busy_left = 25;
        wr_data(32'hCAFE_F00D, 1'b0, 1'b0);
        check(first_strobe_cyc - accept_cyc >= 20, "R3 stall until ready", first_strobe_cyc - accept_cyc, 20);
        wr_addr(32'd11, 1'b0);
        rd_data(1'b0, 1'b0);

        // R9 keep select across a burst
        wr_addr(32'd0, 1'b1);
        repeat (3) @(negedge clk);
        check(hp_cs_n == 0, "R9 select kept", {31'd0, hp_cs_n}, 32'd0);
        wr_data(32'h0F0F_F0F0, 1'b0, 1'b1);
        check(hp_cs_n == 0, "R9 select kept in burst", {31'd0, hp_cs_n}, 32'd0);
        wr_addr(32'd0, 1'b0);
        repeat (2) @(negedge clk);
        check(hp_cs_n == 1, "R9 select released", {31'd0, hp_cs_n}, 32'd1);
        rd_data(1'b0, 1'b0);

        // R7 request during busy is ignored
        issue(2'd2, 1'b1, 1'b1, 1'b0, 32'h7777_8888);
        ref_mem[ref_addr[3:0]] = 32'h7777_8888;
        repeat (4) @(negedge clk);
        req_cmd = 2'd0; req_write = 1'b1; req_wdata = 32'hDEAD_BEEF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        finish_cmd();
        repeat (6) @(negedge clk);
        check(req_busy == 0, "R7 no extra command", {31'd0, req_busy}, 32'd0);
        check(s_ctrl == ref_ctrl, "R7 control untouched", s_ctrl, ref_ctrl);
        rd_data(1'b1, 1'b0);
        check(hp_as_n == 1 && hp_ds_tie == 0, "R10 fixed strobes at end", {30'd0, hp_as_n, hp_ds_tie}, 32'd2);

        repeat (5) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule